// File: doc/BRIEF.md
# Interrupt Queue Pointer Monitor

This block keeps the head and tail pointers of four hypervisor interrupt queues: CPU mondo, device mondo, resumable error and non-resumable error. Whenever a queue's head and tail differ, that queue holds entries that have not been consumed. For the first three queues the block then raises a pending-interrupt line. The non-resumable error queue keeps its pointers and lets them be read back, but it never signals anything.

The same addressed register bus also reaches a trap base address register and a read-only version word. The trap base register always reads with its low 15 bits at zero. The version word packs three configuration values. Software and hardware agents update the pointers through single-cycle writes. Reads return data in the cycle after the request. An access that is not allowed raises a one-cycle error flag.

Register indices on `addr`: a queue's head is at 2*q and its tail at 2*q+1, with q = 0 CPU mondo, 1 device mondo, 2 resumable error, 3 non-resumable error. Index 8 is the trap base register, index 9 is the version word, and indices 10 to 15 are unmapped.

Top module: `intq_ptr_monitor`

## Requirements
- R1: `irqCpuMondo` is high exactly when the CPU mondo head (index 0) differs from its tail (index 1). It takes its new value at the clock edge that performs a write to either pointer.
- R2: `irqDevMondo` (indices 2/3) and `irqResErr` (indices 4/5) follow the same unequal-pointer rule. Each depends only on its own queue.
- R3: The non-resumable error pointers (indices 6/7) are stored and read back in full. Writing them changes no interrupt output.
- R4: A write to the trap base register (index 8) stores the data with bits 14:0 forced to zero. A read of it returns bits 14:0 as zero.
- R5: A read of the version word (index 9) returns the register-window count in bits 7:0, the maximum trap level in bits 15:8 and the maximum global level in bits 23:16. All higher bits read as zero. Defaults: 8, 6, 3.
- R6: Three accesses are errors: a write to index 9, a write to an unmapped index, and a read of an unmapped index. Each sets `errFlag` high for the one cycle after the access and changes no stored state. A read of an unmapped index returns zero.
- R7: After reset all pointers and the trap base are zero, all interrupt outputs and `errFlag` are low, and `rdData` is zero.
- R8: `rdData` shows the addressed register in the cycle after `rdEn`. It holds its value while `rdEn` is low.
- R9: Interrupt outputs change only at a clock edge that performs a write to a queue pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| addr | input | 4 | Register index |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Read data, registered |
| errFlag | output | 1 | One-cycle illegal-access pulse |
| irqCpuMondo | output | 1 | CPU mondo queue not empty |
| irqDevMondo | output | 1 | Device mondo queue not empty |
| irqResErr | output | 1 | Resumable error queue not empty |

## Verification
A table of pointer writes moves the three interrupt lines through every combination. In it, each queue is made unequal and then equal again by writing the head in some steps and the tail in others. This separates a compare on the wrong pair and a missed re-evaluation on one side from correct behaviour. A step that writes only the non-resumable queue shows whether that queue leaks into an output. Equal all-ones pointers test whether the compare covers the full width. Directed accesses to the version word, an unmapped index and the trap base register separate rejected writes from stored ones and show the forced-zero low bits.

// File: rtl/intq_ptr_pkg.sv
package intq_ptr_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_Q   = 4;
  localparam int NUM_PTR = 2 * NUM_Q;
  localparam int NUM_IRQ = NUM_Q - 1;
  localparam logic [ADDR_W-1:0] IDX_TBA = ADDR_W'(NUM_PTR);
  localparam logic [ADDR_W-1:0] IDX_VER = ADDR_W'(NUM_PTR + 1);

  typedef struct packed {
    logic [NUM_PTR-1:0] ptrWe;
    logic               tbaWe;
    logic               rdEn;
    logic [ADDR_W-1:0]  rdIdx;
  } strobes_t;
endpackage

// File: rtl/intq_ptr_ctrl.sv
module intq_ptr_ctrl
  import intq_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb,
  output logic              errFlag
);
  logic isPtr, isTba, isVer, badAccess;

  assign isPtr = (addr < ADDR_W'(NUM_PTR));
  assign isTba = (addr == IDX_TBA);
  assign isVer = (addr == IDX_VER);

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_we
    assign stb.ptrWe[i] = wrEn && (addr == ADDR_W'(i));
  end

  assign stb.tbaWe = wrEn && isTba;
  assign stb.rdEn  = rdEn;
  assign stb.rdIdx = addr;

  assign badAccess = (wrEn && !(isPtr || isTba)) ||
                     (rdEn && !(isPtr || isTba || isVer));

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= badAccess;
  end
endmodule

// File: rtl/intq_ptr_datapath.sv
module intq_ptr_datapath
  import intq_ptr_pkg::*;
#(
  parameter int PTR_W        = 64,
  parameter int WIN_COUNT    = 8,
  parameter int MAX_TL       = 6,
  parameter int MAX_GL       = 3,
  parameter int TBA_LOW_ZERO = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [PTR_W-1:0]   wrData,
  output logic [PTR_W-1:0]   rdData,
  output logic [NUM_IRQ-1:0] irqVec
);
  localparam logic [PTR_W-1:0] TBA_MASK =
    ~((PTR_W'(1) << TBA_LOW_ZERO) - PTR_W'(1));
  localparam logic [PTR_W-1:0] VER_WORD =
    PTR_W'({8'(MAX_GL), 8'(MAX_TL), 8'(WIN_COUNT)});

  logic [PTR_W-1:0] ptrQ [NUM_PTR];
  logic [PTR_W-1:0] tbaQ;
  logic [PTR_W-1:0] rdMux;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)              ptrQ[i] <= '0;
      else if (stb.ptrWe[i])  ptrQ[i] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          tbaQ <= '0;
    else if (stb.tbaWe) tbaQ <= wrData & TBA_MASK;
  end

  // only the first NUM_IRQ queues signal; the last one stays silent
  for (genvar q = 0; q < NUM_IRQ; q++) begin : g_irq
    assign irqVec[q] = (ptrQ[2*q] != ptrQ[2*q+1]);
  end

  always_comb begin
    rdMux = '0;
    if (stb.rdIdx < ADDR_W'(NUM_PTR)) rdMux = ptrQ[stb.rdIdx[$clog2(NUM_PTR)-1:0]];
    else if (stb.rdIdx == IDX_TBA)    rdMux = tbaQ & TBA_MASK;
    else if (stb.rdIdx == IDX_VER)    rdMux = VER_WORD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdMux;
  end
endmodule

// File: rtl/intq_ptr_monitor.sv
module intq_ptr_monitor
  import intq_ptr_pkg::*;
#(
  parameter int PTR_W     = 64,
  parameter int WIN_COUNT = 8,
  parameter int MAX_TL    = 6,
  parameter int MAX_GL    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PTR_W-1:0]  wrData,
  output logic [PTR_W-1:0]  rdData,
  output logic              errFlag,
  output logic              irqCpuMondo,
  output logic              irqDevMondo,
  output logic              irqResErr
);
  strobes_t           stb;
  logic [NUM_IRQ-1:0] irqVec;

  intq_ptr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .stb(stb), .errFlag(errFlag)
  );

  intq_ptr_datapath #(
    .PTR_W(PTR_W), .WIN_COUNT(WIN_COUNT), .MAX_TL(MAX_TL),
    .MAX_GL(MAX_GL), .TBA_LOW_ZERO(15)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .irqVec(irqVec)
  );

  assign irqCpuMondo = irqVec[0];
  assign irqDevMondo = irqVec[1];
  assign irqResErr   = irqVec[2];
endmodule

// File: rtl/intq_ptr_monitor_chk.sv
module intq_ptr_monitor_chk
  import intq_ptr_pkg::*;
#(
  parameter int PTR_W     = 64,
  parameter int WIN_COUNT = 8,
  parameter int MAX_TL    = 6,
  parameter int MAX_GL    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [PTR_W-1:0]  rdData,
  input logic              errFlag,
  input logic              irqCpuMondo,
  input logic              irqDevMondo,
  input logic              irqResErr
);
  logic [2:0] irqs;
  logic       ptrWrite, nresWrite, badWrite;
  assign irqs      = {irqResErr, irqDevMondo, irqCpuMondo};
  assign ptrWrite  = wrEn && (addr < ADDR_W'(NUM_PTR));
  assign nresWrite = wrEn && (addr == ADDR_W'(6) || addr == ADDR_W'(7));
  assign badWrite  = wrEn && (addr >= IDX_VER);

  AST_IRQ_ONLY_ON_PTR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !ptrWrite |=> $stable(irqs)); // R9
  AST_NRES_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    nresWrite |=> $stable(irqs)); // R3
  AST_TBA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == IDX_TBA) |=> (rdData[14:0] == 15'd0)); // R4
  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == IDX_VER) |=>
      (rdData[23:0] == {8'(MAX_GL), 8'(MAX_TL), 8'(WIN_COUNT)})); // R5
  AST_BAD_WRITE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> errFlag); // R6
  AST_BAD_WRITE_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> $stable(irqs)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R8
endmodule

bind intq_ptr_monitor intq_ptr_monitor_chk #(
  .PTR_W(PTR_W), .WIN_COUNT(WIN_COUNT), .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)
) i_chk (.*);

// File: tb/test_intq_ptr_monitor.sv
module test_intq_ptr_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [3:0]  a;
    logic [63:0] d;
    logic [2:0]  irq;   // {res, dev, cpu}
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd1, 64'd5, 3'b001},   // R1 tail write
    '{4'd0, 64'd5, 3'b000},   // R1 head write
    '{4'd2, 64'd7, 3'b010},   // R2
    '{4'd5, 64'd1, 3'b110},   // R2
    '{4'd7, 64'd9, 3'b110},   // R3
    '{4'd3, 64'd7, 3'b100},   // R2
    '{4'd4, 64'd1, 3'b000},   // R2
    '{4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001}, // R1
    '{4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000}, // R1
    '{4'd6, 64'd3, 3'b000}    // R3
  };

  logic        clk = 0, rstN = 0, wrEn = 0, rdEn = 0;
  logic [3:0]  addr = '0;
  logic [63:0] wrData = '0, rdData;
  logic        errFlag, irqCpuMondo, irqDevMondo, irqResErr;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intq_ptr_monitor i_intq_ptr_monitor (.*);

  function automatic logic [2:0] irqs();
    return {irqResErr, irqDevMondo, irqCpuMondo};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [3:0] a, logic [63:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1; wrEn = 0;
  endtask

  task automatic doRead(logic [3:0] a);
    @(negedge clk); rdEn = 1; addr = a;
    @(posedge clk); #1; rdEn = 0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 irqs", 64'(irqs()), 64'd0);
    check("R7 err", 64'(errFlag), 64'd0);
    check("R7 rdData", rdData, 64'd0);
    @(negedge clk); rstN = 1;
    doRead(4'd5);
    check("R7 ptr reset", rdData, 64'd0);

    for (int i = 0; i < NV; i++) begin
      doWrite(VECS[i].a, VECS[i].d);
      check($sformatf("R1/R2/R3 vec %0d irqs", i), 64'(irqs()), 64'(VECS[i].irq));
    end

    doRead(4'd7);
    check("R3 nres tail", rdData, 64'd9);
    doRead(4'd6);
    check("R3 nres head", rdData, 64'd3);
    doRead(4'd0);
    check("R8 cpu head", rdData, 64'hFFFF_FFFF_FFFF_FFFF);
    repeat (2) @(posedge clk);
    #1;
    check("R8 hold", rdData, 64'hFFFF_FFFF_FFFF_FFFF);

    doWrite(4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    doRead(4'd8);
    check("R4 tba", rdData, 64'hFFFF_FFFF_FFFF_8000);

    doRead(4'd9);
    check("R5 version", rdData, 64'h0000_0000_0003_0608);

    doWrite(4'd9, 64'd0);
    check("R6 err ver write", 64'(errFlag), 64'd1);
    @(posedge clk); #1;
    check("R6 err clears", 64'(errFlag), 64'd0);
    doRead(4'd9);
    check("R6 version unchanged", rdData, 64'h0000_0000_0003_0608);

    doWrite(4'd2, 64'd4);
    check("R9 dev irq", 64'(irqs()), 64'b010);
    doWrite(4'd12, 64'd7);
    check("R6 err unmapped write", 64'(errFlag), 64'd1);
    check("R6 irqs unchanged", 64'(irqs()), 64'b010);
    doRead(4'd13);
    check("R6 err unmapped read", 64'(errFlag), 64'd1);
    check("R6 unmapped read zero", rdData, 64'd0);
    doRead(4'd3);
    check("R6 dev tail unchanged", rdData, 64'd7);

    finishRun();
  end
endmodule